// File: doc/BRIEF.md
# AXI-Lite Read Router (one manager, many subordinates)

This block takes read requests from a single AXI4-Lite manager and steers each one to one of several subordinate ports by decoding the read address against a per-port table of regions. Each region is a base address plus an aperture expressed as a number of low address bits. If every base address is left at zero, the table falls back to a packed map in which port k begins at k shifted left by its aperture width. Ports can be flagged as protected: a non-secure request to such a port is refused. A request that matches no region is refused in the same way. A refused request gets a locally generated error beat instead of being forwarded.

Both the read-address and the read-data channels are valid/ready streams. A beat moves only in a cycle in which both valid and ready are high. Once the block raises read-data valid toward the manager, that valid and its payload stay put until the manager takes the beat. Address ready toward the manager is withheld when the in-flight limit for the decoded target is reached, or when the target differs from the one that still has reads outstanding. Read data therefore always comes back in the order the requests were accepted. The address and protection fields are shared by all subordinate ports. Only the selected port sees address valid.

Top module: `axil_rd_router`

## Requirements
- R1: With all base addresses zero, port k answers addresses whose bits above the aperture width equal k; with the default 24-bit aperture, port 1 starts at 0x0100_0000 and port 3 at 0x0300_0000.
- R2: An accepted request raises address valid on exactly the decoded port, with the address and protection passed through unchanged; the request completes only when that port's address ready is high.
- R3: A request matching no region is not forwarded (no port sees address valid); the block returns one read beat with response 2'b11 and all-zero data.
- R4: A request to a protected port with protection bit 1 set (non-secure) is refused like R3; with that bit clear it is forwarded; unprotected ports ignore that bit.
- R5: While MAX_INFLIGHT reads are outstanding, address ready is low and nothing is forwarded; it returns once a read-data beat completes.
- R6: A port whose own in-flight limit is reached gets no further request, even when the total limit has room.
- R7: A request to a different target (another port or the error responder) is held, with ready low, until every read to the current target has returned.
- R8: Read data and response from the current port reach the manager unchanged; read-data ready is given only to the port that owns the oldest outstanding read, so a beat offered by any other port is not taken.
- R9: Synchronous active-high reset clears all outstanding state, so no read-data valid is shown and no read-data ready is given after it.
- R10: Read-data valid toward the manager stays high, with unchanged payload, until the manager asserts ready.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| up_ar_valid | input | 1 | Manager read-address valid |
| up_ar_ready | output | 1 | Manager read-address ready |
| up_ar_addr | input | ADDR_W | Manager read address |
| up_ar_prot | input | 3 | Manager protection bits (bit 1 = non-secure) |
| up_r_valid | output | 1 | Read-data valid to manager |
| up_r_ready | input | 1 | Read-data ready from manager |
| up_r_data | output | DATA_W | Read data to manager |
| up_r_resp | output | 2 | Read response to manager |
| dn_ar_valid | output | NUM_PORTS | Per-port read-address valid |
| dn_ar_ready | input | NUM_PORTS | Per-port read-address ready |
| dn_ar_addr | output | ADDR_W | Shared forwarded address |
| dn_ar_prot | output | 3 | Shared forwarded protection bits |
| dn_r_valid | input | NUM_PORTS | Per-port read-data valid |
| dn_r_ready | output | NUM_PORTS | Per-port read-data ready |
| dn_r_data | input | NUM_PORTS*DATA_W | Per-port read data, port k at bits k*DATA_W upward |
| dn_r_resp | input | NUM_PORTS*2 | Per-port read response, port k at bits 2k upward |

## Verification
The bench builds the router with four ports on the packed default map and 24-bit apertures. Port 2 is protected, the total in-flight limit is 6 and port 1 has its own limit of 2. The small total limit lets the total cap be filled on port 0 within a few requests. Port 1's tighter limit separates the per-port cap from the total cap. The protected port covers both the refused and the forwarded case of the secure check. Addresses from 0x0400_0000 upward fall outside every region and exercise the error responder.

// File: rtl/axil_rd_router_pkg.sv
package axil_rd_router_pkg;
  localparam logic [1:0] RESP_OKAY   = 2'b00;
  localparam logic [1:0] RESP_DECERR = 2'b11;
endpackage

// File: rtl/axil_rd_router_decode.sv
module axil_rd_router_decode #(
  parameter int NUM_PORTS = 4,
  parameter int REGIONS   = 1,
  parameter int ADDR_W    = 32,
  parameter int TW        = 3,
  parameter logic [NUM_PORTS*REGIONS*ADDR_W-1:0] BASE_ADDR = '0,
  parameter logic [NUM_PORTS*REGIONS*32-1:0]     APERTURE  = {(NUM_PORTS*REGIONS){32'd24}},
  parameter logic [NUM_PORTS-1:0]                SECURE    = '0
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic              nonsec,
  output logic [TW-1:0]     tgt,
  output logic              err
);
  localparam int  NREG     = NUM_PORTS * REGIONS;
  localparam bit  PACKED   = (BASE_ADDR == '0);
  localparam logic [TW-1:0] ERR_ID = TW'(NUM_PORTS);

  logic [NREG-1:0]      reg_hit;
  logic [NUM_PORTS-1:0] port_hit;

  // one comparator per region; only bits above the aperture take part
  for (genvar i = 0; i < NREG; i++) begin : g_region
    localparam int AW = int'(APERTURE[i*32 +: 32]);
    localparam logic [ADDR_W-1:0] BASE =
      PACKED ? (ADDR_W'(i) << AW) : BASE_ADDR[i*ADDR_W +: ADDR_W];
    assign reg_hit[i] = ((addr >> AW) == (BASE >> AW));
  end

  for (genvar p = 0; p < NUM_PORTS; p++) begin : g_port
    assign port_hit[p] = |reg_hit[p*REGIONS +: REGIONS];
  end

  // lowest port index wins; secure check applied to the winner
  always_comb begin
    tgt = ERR_ID;
    for (int p = NUM_PORTS - 1; p >= 0; p--) begin
      if (port_hit[p]) tgt = TW'(p);
    end
    for (int p = 0; p < NUM_PORTS; p++) begin
      if (tgt == TW'(p) && SECURE[p] && nonsec) tgt = ERR_ID;
    end
    err = (tgt == ERR_ID);
  end
endmodule

// File: rtl/axil_rd_router_track.sv
module axil_rd_router_track #(
  parameter int TW = 3,
  parameter int CW = 5
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          inc,
  input  logic          dec,
  input  logic [TW-1:0] new_tgt,
  output logic [CW-1:0] cnt,
  output logic [TW-1:0] cur_tgt
);
  always_ff @(posedge clk) begin
    if (rst) begin
      cnt     <= '0;
      cur_tgt <= '0;
    end else begin
      cnt <= cnt + CW'(inc) - CW'(dec);
      if (inc) cur_tgt <= new_tgt;
    end
  end
endmodule

// File: rtl/axil_rd_router_rmux.sv
module axil_rd_router_rmux
  import axil_rd_router_pkg::*;
#(
  parameter int NUM_PORTS = 4,
  parameter int DATA_W    = 32,
  parameter int TW        = 3
) (
  input  logic                        busy,
  input  logic [TW-1:0]               cur_tgt,
  input  logic [NUM_PORTS-1:0]        dn_r_valid,
  input  logic [NUM_PORTS*DATA_W-1:0] dn_r_data,
  input  logic [NUM_PORTS*2-1:0]      dn_r_resp,
  output logic [NUM_PORTS-1:0]        dn_r_ready,
  output logic                        up_r_valid,
  output logic [DATA_W-1:0]           up_r_data,
  output logic [1:0]                  up_r_resp,
  input  logic                        up_r_ready
);
  localparam logic [TW-1:0] ERR_ID = TW'(NUM_PORTS);

  always_comb begin
    up_r_valid = 1'b0;
    up_r_data  = '0;
    up_r_resp  = RESP_OKAY;
    if (busy && cur_tgt == ERR_ID) begin
      up_r_valid = 1'b1;
      up_r_resp  = RESP_DECERR;
    end else if (busy) begin
      for (int p = 0; p < NUM_PORTS; p++) begin
        if (cur_tgt == TW'(p)) begin
          up_r_valid = dn_r_valid[p];
          up_r_data  = dn_r_data[p*DATA_W +: DATA_W];
          up_r_resp  = dn_r_resp[p*2 +: 2];
        end
      end
    end
  end

  for (genvar p = 0; p < NUM_PORTS; p++) begin : g_rdy
    assign dn_r_ready[p] = busy && (cur_tgt == TW'(p)) && up_r_ready;
  end
endmodule

// File: rtl/axil_rd_router.sv
module axil_rd_router #(
  parameter int NUM_PORTS    = 4,
  parameter int REGIONS      = 1,
  parameter int ADDR_W       = 32,
  parameter int DATA_W       = 32,
  parameter int MAX_INFLIGHT = 16,
  parameter logic [NUM_PORTS*REGIONS*ADDR_W-1:0] BASE_ADDR  = '0,
  parameter logic [NUM_PORTS*REGIONS*32-1:0]     APERTURE   = {(NUM_PORTS*REGIONS){32'd24}},
  parameter logic [NUM_PORTS*32-1:0]             PORT_LIMIT = {NUM_PORTS{32'd16}},
  parameter logic [NUM_PORTS-1:0]                SECURE     = '0
) (
  input  logic                        clk,
  input  logic                        rst,
  input  logic                        up_ar_valid,
  output logic                        up_ar_ready,
  input  logic [ADDR_W-1:0]           up_ar_addr,
  input  logic [2:0]                  up_ar_prot,
  output logic                        up_r_valid,
  input  logic                        up_r_ready,
  output logic [DATA_W-1:0]           up_r_data,
  output logic [1:0]                  up_r_resp,
  output logic [NUM_PORTS-1:0]        dn_ar_valid,
  input  logic [NUM_PORTS-1:0]        dn_ar_ready,
  output logic [ADDR_W-1:0]           dn_ar_addr,
  output logic [2:0]                  dn_ar_prot,
  input  logic [NUM_PORTS-1:0]        dn_r_valid,
  output logic [NUM_PORTS-1:0]        dn_r_ready,
  input  logic [NUM_PORTS*DATA_W-1:0] dn_r_data,
  input  logic [NUM_PORTS*2-1:0]      dn_r_resp
);
  localparam int TW = $clog2(NUM_PORTS + 1);
  localparam int CW = $clog2(MAX_INFLIGHT + 1);

  logic [TW-1:0] new_tgt, cur_tgt;
  logic          new_err, sel_rdy, allowed, inc, dec;
  logic [CW-1:0] cnt_q;
  int            lim;

  axil_rd_router_decode #(
    .NUM_PORTS(NUM_PORTS), .REGIONS(REGIONS), .ADDR_W(ADDR_W), .TW(TW),
    .BASE_ADDR(BASE_ADDR), .APERTURE(APERTURE), .SECURE(SECURE)
  ) u_dec (
    .addr(up_ar_addr), .nonsec(up_ar_prot[1]), .tgt(new_tgt), .err(new_err)
  );

  // effective limit: the tighter of the total cap and the target's own cap
  always_comb begin
    lim     = MAX_INFLIGHT;
    sel_rdy = 1'b0;
    for (int p = 0; p < NUM_PORTS; p++) begin
      if (new_tgt == TW'(p)) begin
        sel_rdy = dn_ar_ready[p];
        if (int'(PORT_LIMIT[p*32 +: 32]) < MAX_INFLIGHT) lim = int'(PORT_LIMIT[p*32 +: 32]);
      end
    end
  end

  assign allowed     = ((cnt_q == '0) || (new_tgt == cur_tgt)) && (int'(cnt_q) < lim);
  assign up_ar_ready = allowed && (new_err || sel_rdy);
  assign dn_ar_addr  = up_ar_addr;
  assign dn_ar_prot  = up_ar_prot;

  for (genvar p = 0; p < NUM_PORTS; p++) begin : g_arv
    assign dn_ar_valid[p] = up_ar_valid && allowed && !new_err && (new_tgt == TW'(p));
  end

  assign inc = up_ar_valid && up_ar_ready;
  assign dec = up_r_valid && up_r_ready;

  axil_rd_router_track #(.TW(TW), .CW(CW)) u_trk (
    .clk(clk), .rst(rst), .inc(inc), .dec(dec), .new_tgt(new_tgt),
    .cnt(cnt_q), .cur_tgt(cur_tgt)
  );

  axil_rd_router_rmux #(.NUM_PORTS(NUM_PORTS), .DATA_W(DATA_W), .TW(TW)) u_rmux (
    .busy(cnt_q != '0), .cur_tgt(cur_tgt),
    .dn_r_valid(dn_r_valid), .dn_r_data(dn_r_data), .dn_r_resp(dn_r_resp),
    .dn_r_ready(dn_r_ready), .up_r_valid(up_r_valid), .up_r_data(up_r_data),
    .up_r_resp(up_r_resp), .up_r_ready(up_r_ready)
  );
endmodule

// File: rtl/axil_rd_router_chk.sv
module axil_rd_router_chk #(
  parameter int NUM_PORTS    = 4,
  parameter int DATA_W       = 32,
  parameter int MAX_INFLIGHT = 16,
  parameter int TW           = 3,
  parameter int CW           = 5
) (
  input logic                 clk,
  input logic                 rst,
  input logic                 up_ar_valid,
  input logic                 up_ar_ready,
  input logic                 up_r_valid,
  input logic                 up_r_ready,
  input logic [DATA_W-1:0]    up_r_data,
  input logic [1:0]           up_r_resp,
  input logic [NUM_PORTS-1:0] dn_ar_valid,
  input logic [CW-1:0]        cnt,
  input logic [TW-1:0]        cur_tgt,
  input logic [TW-1:0]        new_tgt,
  input logic                 new_err
);
  localparam logic [TW-1:0] ERR_ID = TW'(NUM_PORTS);

  p_ar_onehot_r2: assert property (@(posedge clk) disable iff (rst)
    $onehot0(dn_ar_valid));

  p_err_not_fwd_r3: assert property (@(posedge clk) disable iff (rst)
    (up_ar_valid && new_err) |-> (dn_ar_valid == '0));

  p_err_zero_data_r3: assert property (@(posedge clk) disable iff (rst)
    (up_r_valid && cur_tgt == ERR_ID) |-> (up_r_data == '0 && up_r_resp == 2'b11));

  p_cap_total_r5: assert property (@(posedge clk) disable iff (rst)
    int'(cnt) <= MAX_INFLIGHT);

  p_same_target_r7: assert property (@(posedge clk) disable iff (rst)
    (up_ar_valid && up_ar_ready && cnt != '0) |-> (new_tgt == cur_tgt));

  p_reset_clear_r9: assert property (@(posedge clk)
    rst |=> (cnt == '0));

  p_r_hold_r10: assert property (@(posedge clk) disable iff (rst)
    (up_r_valid && !up_r_ready) |=> up_r_valid);
endmodule

bind axil_rd_router axil_rd_router_chk #(
  .NUM_PORTS(NUM_PORTS), .DATA_W(DATA_W), .MAX_INFLIGHT(MAX_INFLIGHT),
  .TW(TW), .CW(CW)
) u_chk (
  .clk(clk), .rst(rst), .up_ar_valid(up_ar_valid), .up_ar_ready(up_ar_ready),
  .up_r_valid(up_r_valid), .up_r_ready(up_r_ready), .up_r_data(up_r_data),
  .up_r_resp(up_r_resp), .dn_ar_valid(dn_ar_valid), .cnt(cnt_q),
  .cur_tgt(cur_tgt), .new_tgt(new_tgt), .new_err(new_err)
);

// File: tb/sim_axil_rd_router.sv
module sim_axil_rd_router;
  localparam int N  = 4;
  localparam int AW = 32;
  localparam int DW = 32;

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #10 clk = ~clk;

  logic            up_ar_valid = 1'b0;
  logic            up_ar_ready;
  logic [AW-1:0]   up_ar_addr  = '0;
  logic [2:0]      up_ar_prot  = '0;
  logic            up_r_valid;
  logic            up_r_ready  = 1'b0;
  logic [DW-1:0]   up_r_data;
  logic [1:0]      up_r_resp;
  logic [N-1:0]    dn_ar_valid;
  logic [N-1:0]    dn_ar_ready = '1;
  logic [AW-1:0]   dn_ar_addr;
  logic [2:0]      dn_ar_prot;
  logic [N-1:0]    dn_r_valid  = '0;
  logic [N-1:0]    dn_r_ready;
  logic [N*DW-1:0] dn_r_data   = '0;
  logic [N*2-1:0]  dn_r_resp   = '0;

  axil_rd_router #(
    .NUM_PORTS(N), .ADDR_W(AW), .DATA_W(DW), .MAX_INFLIGHT(6),
    .PORT_LIMIT({32'd16, 32'd16, 32'd2, 32'd16}), .SECURE(4'b0100)
  ) u0 (.*);

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  // present one request for one cycle and check the handshake outcome
  task automatic ar_step(input logic [AW-1:0] a, input logic [2:0] pr,
                         input bit exp_rdy, input logic [N-1:0] exp_dv, input string tag);
    @(negedge clk);
    up_ar_valid = 1'b1; up_ar_addr = a; up_ar_prot = pr;
    #1;
    chk(up_ar_ready == exp_rdy, {tag, " ready"}, 64'(up_ar_ready), 64'(exp_rdy));
    chk(dn_ar_valid == exp_dv, {tag, " dn_valid"}, 64'(dn_ar_valid), 64'(exp_dv));
    if (exp_dv != '0) begin
      chk(dn_ar_addr == a && dn_ar_prot == pr, {tag, " fwd addr"}, 64'(dn_ar_addr), 64'(a));
    end
    @(posedge clk); #1;
    up_ar_valid = 1'b0;
  endtask

  // port < N: subordinate offers a beat; port == N: expect the error beat
  task automatic r_step(input int port, input logic [DW-1:0] d, input logic [1:0] rs, input string tag);
    @(negedge clk);
    if (port < N) begin
      dn_r_valid[port] = 1'b1;
      dn_r_data[port*DW +: DW] = d;
      dn_r_resp[port*2 +: 2] = rs;
    end
    up_r_ready = 1'b1;
    #1;
    chk(up_r_valid == 1'b1, {tag, " r_valid"}, 64'(up_r_valid), 64'd1);
    chk(up_r_data == d && up_r_resp == rs, {tag, " r_payload"},
        {30'd0, up_r_resp, up_r_data}, {30'd0, rs, d});
    @(posedge clk); #1;
    dn_r_valid = '0; up_r_ready = 1'b0;
  endtask

  task automatic t_reset();
    #1;
    chk(up_r_valid == 1'b0 && dn_ar_valid == '0 && dn_r_ready == '0, "R9 in reset",
        {up_r_valid, dn_ar_valid, dn_r_ready}, 64'd0);
    repeat (3) @(posedge clk);
    #1 rst = 1'b0;
    ar_step(32'h0000_0040, 3'b000, 1'b1, 4'b0001, "R9 pre");
    @(negedge clk); rst = 1'b1;
    @(negedge clk); rst = 1'b0; dn_r_valid[0] = 1'b1;
    #1;
    chk(up_r_valid == 1'b0 && dn_r_ready == '0, "R9 cleared", {up_r_valid, dn_r_ready}, 64'd0);
    dn_r_valid = '0;
  endtask

  task automatic t_map();
    for (int k = 0; k < N; k++) begin
      ar_step((32'(k) << 24) | 32'h1234, 3'b000, 1'b1, 4'(1 << k), "R1/R2 map");
      r_step(k, 32'hA000_0000 + 32'(k), 2'b00, "R8 data");
    end
    ar_step(32'h01FF_FFFC, 3'b000, 1'b1, 4'b0010, "R1 top of port1");
    r_step(1, 32'h5555_AAAA, 2'b10, "R8 resp passthrough");
    @(negedge clk); dn_ar_ready[3] = 1'b0;
    ar_step(32'h0300_0000, 3'b000, 1'b0, 4'b1000, "R2 backpressure");
    dn_ar_ready[3] = 1'b1;
    ar_step(32'h0300_0000, 3'b000, 1'b1, 4'b1000, "R2 after ready");
    r_step(3, 32'h3333_0000, 2'b00, "R2 drain");
  endtask

  task automatic t_unmapped();
    ar_step(32'h0500_0000, 3'b000, 1'b1, 4'b0000, "R3 unmapped");
    @(negedge clk); #1;
    chk(up_r_valid && up_r_resp == 2'b11 && up_r_data == '0, "R3 err beat",
        {up_r_valid, up_r_resp, up_r_data}, {1'b1, 2'b11, 32'd0});
    @(negedge clk); #1;
    chk(up_r_valid == 1'b1, "R10 held", 64'(up_r_valid), 64'd1);
    r_step(N, 32'd0, 2'b11, "R3 err taken");
    @(negedge clk); #1;
    chk(up_r_valid == 1'b0, "R3 single beat", 64'(up_r_valid), 64'd0);
  endtask

  task automatic t_secure();
    ar_step(32'h0200_0010, 3'b010, 1'b1, 4'b0000, "R4 refused");
    r_step(N, 32'd0, 2'b11, "R4 err beat");
    ar_step(32'h0200_0010, 3'b000, 1'b1, 4'b0100, "R4 secure ok");
    r_step(2, 32'h2222_2222, 2'b00, "R4 data");
    ar_step(32'h0000_0010, 3'b010, 1'b1, 4'b0001, "R4 unprotected");
    r_step(0, 32'h0000_1111, 2'b00, "R4 data0");
  endtask

  task automatic t_order();
    ar_step(32'h0000_0100, 3'b000, 1'b1, 4'b0001, "R7 first");
    ar_step(32'h0100_0100, 3'b000, 1'b0, 4'b0000, "R7 other port held");
    ar_step(32'h0700_0000, 3'b000, 1'b0, 4'b0000, "R7 error held");
    @(negedge clk); dn_r_valid[1] = 1'b1; up_r_ready = 1'b1;
    #1;
    chk(dn_r_ready[1] == 1'b0 && up_r_valid == 1'b0, "R8 stray not taken",
        {dn_r_ready[1], up_r_valid}, 64'd0);
    @(posedge clk); #1; dn_r_valid = '0; up_r_ready = 1'b0;
    r_step(0, 32'hCAFE_0000, 2'b00, "R7 first data");
    ar_step(32'h0100_0100, 3'b000, 1'b1, 4'b0010, "R7 switch after drain");
    r_step(1, 32'hCAFE_0001, 2'b00, "R7 second data");
  endtask

  task automatic t_total();
    for (int i = 0; i < 6; i++) ar_step(32'h0000_0200, 3'b000, 1'b1, 4'b0001, "R5 fill");
    ar_step(32'h0000_0200, 3'b000, 1'b0, 4'b0000, "R5 cap");
    r_step(0, 32'h0000_0500, 2'b00, "R5 drain one");
    ar_step(32'h0000_0200, 3'b000, 1'b1, 4'b0001, "R5 reopen");
    for (int i = 0; i < 6; i++) r_step(0, 32'h0000_0600 + 32'(i), 2'b00, "R5 drain");
  endtask

  task automatic t_port();
    for (int i = 0; i < 2; i++) ar_step(32'h0100_0300, 3'b000, 1'b1, 4'b0010, "R6 fill");
    ar_step(32'h0100_0300, 3'b000, 1'b0, 4'b0000, "R6 port cap");
    r_step(1, 32'h0000_6001, 2'b00, "R6 drain");
    ar_step(32'h0100_0300, 3'b000, 1'b1, 4'b0010, "R6 reopen");
    for (int i = 0; i < 2; i++) r_step(1, 32'h0000_6100, 2'b00, "R6 drain");
  endtask

  initial begin
    t_reset();
    t_map();
    t_unmapped();
    t_secure();
    t_order();
    t_total();
    t_port();
    repeat (2) @(posedge clk);
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end
endmodule